// File: doc/BRIEF.md
# Single-Stream DMA Transfer Engine

This block is one DMA stream. It moves a programmed number of data items from a source to a destination. One side is a peripheral address and the other is a memory address. Software sets the stream up through a small register port: a control word, a peripheral address, two memory base addresses and an item count. Software then sets the enable bit. The engine reads each item through a single-beat bus master and parks it in a four-word FIFO. It later writes the item out through the same master. A three-bit channel field picks which of eight request lines paces the peripheral side.

The direction field selects one of three routes. The engine can fetch from the peripheral and store to memory, or fetch from memory and store to the peripheral. It can also copy memory to memory, with the peripheral address register as the source; this route runs without waiting for a request. Each side has its own item size, and each address steps by its own size after every item. When the last item is written, a one-shot stream turns itself off and raises a sticky done flag. A circular stream instead reloads its count and addresses and carries on.

The bus request uses valid/ready. The engine holds address, write flag, size and write data steady while valid is high and ready is low. It does not withdraw the request before acceptance. At most one access is outstanding. After an accepted read, the engine waits for exactly one response beat on `bus_rsp_valid` and cannot stall that beat. The read item is taken from the low bits of the response. The write item sits in the low bits of `bus_req_wdata`, and the bits above the destination size are zero.

Top module: `dma_stream_engine`

Register map, selected by `reg_addr`:
- 0 is control. Bit 0 is enable, bits 3:1 are the channel and bit 4 is circular mode. Bits 6:5 are the direction. Bits 8:7 are the peripheral size and bits 10:9 are the memory size. Bit 11 selects the memory target. Bit 12 reads as the done flag, and writing 1 to it clears the flag.
- 1 is the peripheral address.
- 2 is memory base 0.
- 3 is memory base 1.
- 4 is the item count. A read returns the number of items still to be written.

## Requirements
- R1: After reset the control register reads 0: the stream is disabled, the direction is 00, circular mode is off, both sizes are 00 and done is 0. No bus request is raised.
- R2: With direction 00 (peripheral to memory), every read fetches from the peripheral address and starts only while the request line picked by the channel field is high. Writes go to the selected memory base.
- R3: With direction 01 (memory to peripheral), reads fetch from the selected memory base. Every write to the peripheral address starts only while the selected request line is high.
- R4: With direction 10 (memory to memory), items go from the peripheral address register to the selected memory base without any request line.
- R5: The size encodings are 00 for 8 bits, 01 for 16 bits and 10 for 32 bits; 11 steps like 32 bits. Each address advances by 1, 2 or 4 according to its own size. A written item is the read item cut to the narrower of the two sizes.
- R6: While enable is 1, a control write can only clear enable and done. Writes to the addresses and the count are ignored, and the sizes, direction, channel and circular bit stay unchanged.
- R7: The count register reads the number of items not yet written. It falls by one for each accepted write.
- R8: After the last write of a non-circular stream, enable reads 0 and done reads 1. Done stays at 1 until a control write with bit 12 set.
- R9: In circular mode, after the last write the count and both addresses reload and the transfer restarts. Done is not set.
- R10: Direction 11 with enable 1 produces no bus traffic.
- R11: Control bit 11 at 0 targets memory base 0 and at 1 targets memory base 1.
- R12: No more than four items are read ahead of the writes.
- R13: A bus request waiting for ready keeps valid high and its address, write flag and data unchanged.
- R14: Enabling with a count of 0 sets done and clears enable with no bus traffic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| dma_req | input | 8 | Peripheral request lines, one per channel |
| bus_req_valid | output | 1 | Bus access request valid |
| bus_req_ready | input | 1 | Bus accepts the request |
| bus_req_write | output | 1 | 1 for write, 0 for read |
| bus_req_addr | output | 32 | Access byte address |
| bus_req_size | output | 2 | Access item size code |
| bus_req_wdata | output | 32 | Write item, low-aligned |
| bus_rsp_valid | input | 1 | Read response beat |
| bus_rsp_data | input | 32 | Read response data, low-aligned |

## Verification
The properties assume that `bus_rsp_valid` pulses exactly once after each accepted read and never at any other time. They also assume that software does not re-enable the stream while a previous access is still in flight. The bench memory model answers one cycle after acceptance and holds ready either always high or toggling every cycle. Request lines change only at falling edges, and the stream is re-enabled only after it has stopped and been left idle.

// File: rtl/dma_stream_pkg.sv
package dma_stream_pkg;
  localparam int WORD_W = 32;
  localparam int CH_W   = 3;
  localparam int NUM_REQ = 1 << CH_W;

  typedef enum logic [1:0] {
    DIR_P2M  = 2'b00,
    DIR_M2P  = 2'b01,
    DIR_M2M  = 2'b10,
    DIR_NONE = 2'b11
  } dir_e;

  // field order gives control bits 11..1
  typedef struct packed {
    logic            mem_sel;
    logic [1:0]      msize;
    logic [1:0]      psize;
    dir_e            dir;
    logic            circ;
    logic [CH_W-1:0] chan;
  } cfg_t;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_PADDR = 3'd1;
  localparam logic [2:0] RA_MB0   = 3'd2;
  localparam logic [2:0] RA_MB1   = 3'd3;
  localparam logic [2:0] RA_COUNT = 3'd4;

  function automatic logic [2:0] size_step(input logic [1:0] sz);
    case (sz)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'b00:   return 32'h0000_00FF;
      2'b01:   return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/dma_stream_regs.sv
module dma_stream_regs
  import dma_stream_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              finish,
  output cfg_t              cfg,
  output logic              enable,
  output logic              start,
  output logic              cnt_wr,
  output logic              done,
  output logic [ADDR_W-1:0] paddr,
  output logic [ADDR_W-1:0] mbase0,
  output logic [ADDR_W-1:0] mbase1,
  output logic [CNT_W-1:0]  count_prog
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg        <= '0;
      enable     <= 1'b0;
      start      <= 1'b0;
      cnt_wr     <= 1'b0;
      done       <= 1'b0;
      paddr      <= '0;
      mbase0     <= '0;
      mbase1     <= '0;
      count_prog <= '0;
    end else begin
      start  <= 1'b0;
      cnt_wr <= 1'b0;
      if (finish) begin
        enable <= 1'b0;
        done   <= 1'b1;
      end
      if (reg_wr) begin
        case (reg_addr)
          RA_CTRL: begin
            if (!enable) begin
              cfg    <= cfg_t'(reg_wdata[11:1]);
              enable <= reg_wdata[0];
              start  <= reg_wdata[0];
            end else if (!reg_wdata[0]) begin
              enable <= 1'b0;
            end
            if (reg_wdata[12]) done <= 1'b0;
          end
          RA_PADDR: if (!enable) paddr  <= reg_wdata[ADDR_W-1:0];
          RA_MB0:   if (!enable) mbase0 <= reg_wdata[ADDR_W-1:0];
          RA_MB1:   if (!enable) mbase1 <= reg_wdata[ADDR_W-1:0];
          RA_COUNT: if (!enable) begin
            count_prog <= reg_wdata[CNT_W-1:0];
            cnt_wr     <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_stream_fifo.sv
module dma_stream_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [OCC_W-1:0] occ;
  logic             do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign full    = (occ == OCC_W'(DEPTH));
  assign empty   = (occ == '0);
  assign head    = slots[rp];

  always_ff @(posedge clk) begin
    if (do_push) slots[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp  <= '0;
      rp  <= '0;
      occ <= '0;
    end else begin
      if (do_push) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
      occ <= occ + OCC_W'(do_push) - OCC_W'(do_pop);
    end
  end
endmodule

// File: rtl/dma_stream_mover.sv
module dma_stream_mover
  import dma_stream_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_t              cfg,
  input  logic              enable,
  input  logic              start,
  input  logic              cnt_wr,
  input  logic              dreq_sel,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [ADDR_W-1:0] mbase0,
  input  logic [ADDR_W-1:0] mbase1,
  input  logic [CNT_W-1:0]  count_prog,
  input  logic              fifo_full,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_head,
  output logic              fifo_push,
  output logic              fifo_pop,
  output logic [WORD_W-1:0] fifo_wdata,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic              bus_req_write,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [1:0]        bus_req_size,
  output logic [WORD_W-1:0] bus_req_wdata,
  input  logic              bus_rsp_valid,
  input  logic [WORD_W-1:0] bus_rsp_data,
  output logic              finish,
  output logic [CNT_W-1:0]  items_left
);
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WAIT, ST_WR} st_e;

  st_e               state;
  logic [ADDR_W-1:0] src_addr, dst_addr, mbase_sel, src_base, dst_base;
  logic [CNT_W-1:0]  rd_left, wr_left;
  logic [1:0]        src_size, dst_size;
  logic              src_is_periph, rd_gate, wr_gate;

  assign mbase_sel     = cfg.mem_sel ? mbase1 : mbase0;
  assign src_is_periph = (cfg.dir != DIR_M2P);
  assign src_base      = src_is_periph ? paddr : mbase_sel;
  assign dst_base      = src_is_periph ? mbase_sel : paddr;
  assign src_size      = src_is_periph ? cfg.psize : cfg.msize;
  assign dst_size      = src_is_periph ? cfg.msize : cfg.psize;
  assign rd_gate = (cfg.dir == DIR_P2M) ? dreq_sel
                 : (cfg.dir == DIR_M2P || cfg.dir == DIR_M2M);
  assign wr_gate = (cfg.dir == DIR_M2P) ? dreq_sel
                 : (cfg.dir == DIR_P2M || cfg.dir == DIR_M2M);

  assign bus_req_valid = (state == ST_RD) || (state == ST_WR);
  assign bus_req_write = (state == ST_WR);
  assign bus_req_addr  = (state == ST_WR) ? dst_addr : src_addr;
  assign bus_req_size  = (state == ST_WR) ? dst_size : src_size;
  assign bus_req_wdata = fifo_head & size_mask(dst_size);
  assign fifo_push     = (state == ST_WAIT) && bus_rsp_valid;
  assign fifo_wdata    = bus_rsp_data & size_mask(src_size);
  assign fifo_pop      = (state == ST_WR) && bus_req_ready;
  assign items_left    = wr_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      src_addr <= '0;
      dst_addr <= '0;
      rd_left  <= '0;
      wr_left  <= '0;
      finish   <= 1'b0;
    end else begin
      finish <= 1'b0;
      case (state)
        ST_IDLE: if (enable && !start && !finish) begin
          if (wr_left == '0)                                  finish <= 1'b1;
          else if (wr_gate && !fifo_empty)                    state  <= ST_WR;
          else if (rd_gate && !fifo_full && rd_left != '0)    state  <= ST_RD;
        end
        ST_RD: if (bus_req_ready) state <= ST_WAIT;
        ST_WAIT: if (bus_rsp_valid) begin
          src_addr <= src_addr + ADDR_W'(size_step(src_size));
          rd_left  <= rd_left - 1'b1;
          state    <= ST_IDLE;
        end
        ST_WR: if (bus_req_ready) begin
          dst_addr <= dst_addr + ADDR_W'(size_step(dst_size));
          wr_left  <= wr_left - 1'b1;
          state    <= ST_IDLE;
          if (wr_left == CNT_W'(1)) begin
            if (cfg.circ) begin
              src_addr <= src_base;
              dst_addr <= dst_base;
              rd_left  <= count_prog;
              wr_left  <= count_prog;
            end else begin
              finish <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (start) begin
        src_addr <= src_base;
        dst_addr <= dst_base;
        rd_left  <= count_prog;
        wr_left  <= count_prog;
      end else if (cnt_wr) begin
        wr_left <= count_prog;
      end
    end
  end
endmodule

// File: rtl/dma_stream_engine.sv
module dma_stream_engine
  import dma_stream_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_REQ-1:0] dma_req,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic              bus_req_write,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [1:0]        bus_req_size,
  output logic [WORD_W-1:0] bus_req_wdata,
  input  logic              bus_rsp_valid,
  input  logic [WORD_W-1:0] bus_rsp_data
);
  cfg_t              cfg_q;
  logic              en_q, start_p, cnt_wr_p, done_q, finish_p;
  logic [ADDR_W-1:0] paddr_q, mb0_q, mb1_q;
  logic [CNT_W-1:0]  count_q, left_w;
  logic              f_push, f_pop, f_full, f_empty;
  logic [WORD_W-1:0] f_wdata, f_head;

  dma_stream_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .finish(finish_p), .cfg(cfg_q), .enable(en_q),
    .start(start_p), .cnt_wr(cnt_wr_p), .done(done_q), .paddr(paddr_q),
    .mbase0(mb0_q), .mbase1(mb1_q), .count_prog(count_q)
  );

  dma_stream_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) fifo_i (
    .clk(clk), .rst_n(rst_n), .flush(start_p), .push(f_push), .wdata(f_wdata),
    .pop(f_pop), .head(f_head), .full(f_full), .empty(f_empty)
  );

  dma_stream_mover #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) mover_i (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .enable(en_q), .start(start_p),
    .cnt_wr(cnt_wr_p), .dreq_sel(dma_req[cfg_q.chan]), .paddr(paddr_q),
    .mbase0(mb0_q), .mbase1(mb1_q), .count_prog(count_q),
    .fifo_full(f_full), .fifo_empty(f_empty), .fifo_head(f_head),
    .fifo_push(f_push), .fifo_pop(f_pop), .fifo_wdata(f_wdata),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_write(bus_req_write), .bus_req_addr(bus_req_addr),
    .bus_req_size(bus_req_size), .bus_req_wdata(bus_req_wdata),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_data(bus_rsp_data),
    .finish(finish_p), .items_left(left_w)
  );

  always_comb begin
    case (reg_addr)
      RA_CTRL:  reg_rdata = {19'b0, done_q, cfg_q, en_q};
      RA_PADDR: reg_rdata = 32'(paddr_q);
      RA_MB0:   reg_rdata = 32'(mb0_q);
      RA_MB1:   reg_rdata = 32'(mb1_q);
      RA_COUNT: reg_rdata = 32'(left_w);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_stream_checker.sv
module dma_stream_checker
  import dma_stream_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int FIFO_DEPTH = 4
) (
  input logic               clk,
  input logic               rst_n,
  input cfg_t               cfg,
  input logic               enable,
  input logic               done,
  input logic               start,
  input logic [NUM_REQ-1:0] dma_req,
  input logic               bus_req_valid,
  input logic               bus_req_ready,
  input logic               bus_req_write,
  input logic [ADDR_W-1:0]  bus_req_addr,
  input logic [WORD_W-1:0]  bus_req_wdata,
  input logic               bus_rsp_valid
);
  logic [7:0] ahead;
  logic       rd_pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ahead      <= '0;
      rd_pending <= 1'b0;
    end else begin
      if (bus_req_valid && bus_req_ready && !bus_req_write) rd_pending <= 1'b1;
      else if (bus_rsp_valid)                               rd_pending <= 1'b0;
      if (start) ahead <= '0;
      else ahead <= ahead + 8'(rd_pending && bus_rsp_valid)
                          - 8'(bus_req_valid && bus_req_ready && bus_req_write);
    end
  end

  AST_P2M_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req_valid) && !bus_req_write && cfg.dir == DIR_P2M |-> $past(dma_req[cfg.chan])); // R2
  AST_M2P_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req_valid) && bus_req_write && cfg.dir == DIR_M2P |-> $past(dma_req[cfg.chan])); // R3
  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    enable && $past(enable) |-> $stable(cfg)); // R6
  AST_DONE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !enable); // R8
  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.dir == DIR_NONE |-> !$rose(bus_req_valid)); // R10
  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ahead <= 8'(FIFO_DEPTH)); // R12
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_req_addr)
      && $stable(bus_req_write) && $stable(bus_req_wdata)); // R13
endmodule

bind dma_stream_engine dma_stream_checker #(.ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .enable(en_q), .done(done_q),
  .start(start_p), .dma_req(dma_req), .bus_req_valid(bus_req_valid),
  .bus_req_ready(bus_req_ready), .bus_req_write(bus_req_write),
  .bus_req_addr(bus_req_addr), .bus_req_wdata(bus_req_wdata),
  .bus_rsp_valid(bus_rsp_valid)
);

// File: tb/dma_stream_engine_tb.sv
`timescale 1ns/1ps
module dma_stream_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  dma_req = '0;
  logic        bus_req_valid, bus_req_write;
  logic        bus_req_ready = 1'b1;
  logic [31:0] bus_req_addr, bus_req_wdata;
  logic [1:0]  bus_req_size;
  logic        bus_rsp_valid = 1'b0;
  logic [31:0] bus_rsp_data = '0;

  always #10 clk = ~clk;

  dma_stream_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_req(dma_req),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_write(bus_req_write), .bus_req_addr(bus_req_addr),
    .bus_req_size(bus_req_size), .bus_req_wdata(bus_req_wdata),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_data(bus_rsp_data)
  );

  localparam logic [31:0] PA = 32'h4000_0000, MA0 = 32'h2000_0000, MA1 = 32'h3000_0000;

  typedef struct packed {
    logic [1:0]  dir;
    logic [1:0]  ps;
    logic [1:0]  ms;
    logic        msel;
    logic [2:0]  chan;
    logic        stall;
    logic [7:0]  n;
    logic [31:0] last;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{2'b00, 2'b00, 2'b10, 1'b0, 3'd2, 1'b0, 8'd3, 32'h2000_0008},
    '{2'b01, 2'b01, 2'b00, 1'b0, 3'd5, 1'b0, 8'd4, 32'h4000_0006},
    '{2'b10, 2'b10, 2'b01, 1'b0, 3'd0, 1'b1, 8'd5, 32'h2000_0008},
    '{2'b00, 2'b01, 2'b01, 1'b1, 3'd7, 1'b1, 8'd2, 32'h3000_0002}
  };

  int checks = 0, fails = 0, cyc = 0;
  logic stall = 1'b0;
  logic [31:0] log_addr [128];
  logic [31:0] log_data [128];
  int log_n = 0, rd_n = 0;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[7:0] + 8'd3, a[7:0] + 8'd2, a[7:0] + 8'd1, a[7:0]} ^ 32'h5A00_0000;
  endfunction
  function automatic logic [31:0] stp(input logic [1:0] s);
    return (s == 2'b00) ? 32'd1 : (s == 2'b01) ? 32'd2 : 32'd4;
  endfunction
  function automatic logic [31:0] msk(input logic [1:0] s);
    return (s == 2'b00) ? 32'hFF : (s == 2'b01) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction
  function automatic logic [31:0] ctrl(input logic [1:0] dir, ps, ms, input logic msel,
                                       input logic [2:0] ch, input logic circ);
    return 32'(1) | (32'(ch) << 1) | (32'(circ) << 4) | (32'(dir) << 5) | (32'(ps) << 7)
         | (32'(ms) << 9) | (32'(msel) << 11) | 32'h1000;
  endfunction

  // memory model: answer one cycle after an accepted read, log writes
  always @(posedge clk) begin
    cyc <= cyc + 1;
    bus_rsp_valid <= bus_req_valid && bus_req_ready && !bus_req_write;
    bus_rsp_data  <= pat(bus_req_addr);
    if (bus_req_valid && bus_req_ready) begin
      if (bus_req_write) begin
        log_addr[log_n[6:0]] <= bus_req_addr;
        log_data[log_n[6:0]] <= bus_req_wdata;
        log_n <= log_n + 1;
      end else begin
        rd_n <= rd_n + 1;
      end
    end
  end
  always @(negedge clk) bus_req_ready <= stall ? ~bus_req_ready : 1'b1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask
  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask
  task automatic wait_done(output logic [31:0] c);
    for (int i = 0; i < 3000; i++) begin
      rd(3'd0, c);
      if (c[12]) break;
    end
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    fails++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] c, v;
    int b, r0, bad;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3'd0, c);
    check(c == 32'h0, "R1 control after reset", c, 0);
    check(!bus_req_valid, "R1 no request after reset", 32'(bus_req_valid), 0);
    wr(3'd1, PA); wr(3'd2, MA0); wr(3'd3, MA1);

    // table of vectors
    for (int k = 0; k < 4; k++) begin
      automatic vec_t t = VEC[k];
      automatic logic [31:0] sb = (t.dir == 2'b01) ? (t.msel ? MA1 : MA0) : PA;
      automatic logic [1:0]  ss = (t.dir == 2'b01) ? t.ms : t.ps;
      automatic logic [1:0]  ds = (t.dir == 2'b01) ? t.ps : t.ms;
      automatic string tag = (t.dir == 2'b01) ? "R3" : (t.dir == 2'b10) ? "R4"
                           : (t.msel ? "R11" : "R2");
      b = log_n;
      wr(3'd4, 32'(t.n));
      stall = t.stall;
      dma_req = 8'(1) << t.chan;
      wr(3'd0, ctrl(t.dir, t.ps, t.ms, t.msel, t.chan, 1'b0));
      wait_done(c);
      repeat (3) @(negedge clk);
      stall = 1'b0; dma_req = '0;
      check(c[12] && !c[0], "R8 done set, enable cleared", c, 32'h1000);
      check(log_n - b == int'(t.n), tag, 32'(log_n - b), 32'(t.n));
      check(log_addr[(b + t.n - 1) % 128] == t.last, tag, log_addr[(b + t.n - 1) % 128], t.last);
      bad = 0;
      for (int i = 0; i < int'(t.n); i++)
        if (log_data[(b + i) % 128] != (pat(sb + 32'(i) * stp(ss)) & msk(ss) & msk(ds))) bad++;
      check(bad == 0, "R5 item data and widths", 32'(bad), 0);
      rd(3'd4, v);
      check(v == 0, "R7 count at end", v, 0);
      if (t.stall) check(log_n - b == int'(t.n), "R13 complete under back-pressure",
                         32'(log_n - b), 32'(t.n));
    end

    // R2 gating and R6 locking
    b = log_n; r0 = rd_n;
    wr(3'd4, 32'd2);
    dma_req = 8'hBF;
    wr(3'd0, ctrl(2'b00, 2'b00, 2'b00, 1'b0, 3'd6, 1'b0));
    repeat (40) @(negedge clk);
    check(rd_n == r0, "R2 no read without selected request", 32'(rd_n - r0), 0);
    wr(3'd0, 32'h0000_07A3);
    wr(3'd1, 32'h1234_5678);
    rd(3'd0, c);
    check(c[11:0] == 12'h0D, "R6 control fields locked", 32'(c[11:0]), 32'h0D);
    rd(3'd1, v);
    check(v == PA, "R6 address locked", v, PA);
    dma_req = 8'h40;
    wait_done(c);
    dma_req = '0;
    check(c[12] && log_n - b == 2, "R2 completes once requested", 32'(log_n - b), 2);

    // R12 read-ahead bound, R3 write gating, R7 live count
    b = log_n; r0 = rd_n;
    wr(3'd4, 32'd6);
    wr(3'd0, ctrl(2'b01, 2'b00, 2'b10, 1'b0, 3'd1, 1'b0));
    repeat (40) @(negedge clk);
    check(rd_n - r0 == 4, "R12 read-ahead limited to four", 32'(rd_n - r0), 4);
    check(log_n == b, "R3 no write without request", 32'(log_n - b), 0);
    rd(3'd4, v);
    check(v == 6, "R7 count before writes", v, 6);
    dma_req = 8'h02;
    wait_done(c);
    dma_req = '0;
    bad = 0;
    for (int i = 0; i < 6; i++)
      if (log_addr[(b + i) % 128] != PA + 32'(i) ||
          log_data[(b + i) % 128] != (pat(MA0 + 32'(4 * i)) & 32'hFF)) bad++;
    check(bad == 0 && log_n - b == 6, "R3 memory to peripheral items", 32'(bad), 0);

    // R10 reserved direction
    b = log_n; r0 = rd_n;
    wr(3'd4, 32'd3);
    dma_req = 8'hFF;
    wr(3'd0, ctrl(2'b11, 2'b00, 2'b00, 1'b0, 3'd0, 1'b0));
    repeat (40) @(negedge clk);
    rd(3'd0, c);
    check(c[0] && log_n == b && rd_n == r0, "R10 reserved direction idle", 32'(log_n - b + rd_n - r0), 0);
    wr(3'd0, 32'h0);
    dma_req = '0;

    // R14 zero count
    b = log_n; r0 = rd_n;
    wr(3'd4, 32'd0);
    wr(3'd0, ctrl(2'b10, 2'b00, 2'b00, 1'b0, 3'd0, 1'b0));
    repeat (6) @(negedge clk);
    rd(3'd0, c);
    check(c[12] && !c[0] && log_n == b && rd_n == r0, "R14 zero count finishes", c, 32'h1000);

    // R9 circular
    b = log_n;
    wr(3'd4, 32'd2);
    wr(3'd0, ctrl(2'b10, 2'b00, 2'b00, 1'b0, 3'd0, 1'b1) | 32'h10);
    for (int i = 0; i < 2000 && log_n - b < 5; i++) @(negedge clk);
    wr(3'd0, 32'h0);
    repeat (10) @(negedge clk);
    check(log_addr[(b + 2) % 128] == MA0, "R9 destination reloaded", log_addr[(b + 2) % 128], MA0);
    check(log_data[(b + 2) % 128] == (pat(PA) & 32'hFF), "R9 source reloaded",
          log_data[(b + 2) % 128], pat(PA) & 32'hFF);
    rd(3'd0, c);
    check(!c[12], "R9 circular never sets done", c, 0);

    // R8 sticky done cleared by write
    wr(3'd4, 32'd1);
    wr(3'd0, ctrl(2'b10, 2'b00, 2'b00, 1'b0, 3'd0, 1'b0));
    wait_done(c);
    repeat (5) @(negedge clk);
    rd(3'd0, c);
    check(c[12], "R8 done sticky", c, 32'h1000);
    wr(3'd0, 32'h1000);
    rd(3'd0, c);
    check(!c[12], "R8 done cleared by write", c, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule